// File: doc/BRIEF.md
# RR Interval Two-Section Frame Buffer

This block collects RR intervals (beat-to-beat times) from a beat detector and serves them to a spectral engine over two-minute windows. Each window overlaps the one before it by half. Storage is split into two equal sections, and each section holds one minute of intervals. While incoming intervals fill one section, the other section keeps the previous minute. At every minute boundary, the two sections swap roles. The new window is then streamed out as the older minute followed by the newer minute.

When a section is closed, its element count is frozen. A sequential divider then computes the section's integer mean from a running sum. The window mean that goes with each stream is the average of the two stored section means. The minute that is shared with the next window keeps its mean, so no pass over the whole window is needed. A section holds at most 256 entries, which is enough for 220 beats per minute. Any interval arriving beyond that limit is discarded and latches an overflow flag.

The consumer must take the older frame of a window before the first interval of the new minute arrives. This is because that section is being refilled. The readout lasts a few hundred cycles, while the gap between beats is many millions of cycles.

Top module: `rr_frame_pingpong`

## Requirements
- R1: After reset, `rd_valid_o`, `rd_last_o` and `ovf_o` are 0 and `win_mean_o` is 0.
- R2: No window is streamed until two frame ticks have closed two frames.
- R3: After the second tick, and after every later tick, one window is streamed. It contains the entries of the older closed frame in arrival order, followed by the entries of the newer closed frame in arrival order. The newer frame of one window is the older frame of the next window.
- R4: `rd_last_o` is 1 only on the final entry of a window. While `rd_valid_o` is 1 and `rd_ready_i` is 0, `rd_valid_o`, `rd_data_o` and `rd_last_o` hold their values.
- R5: An interval presented in the same cycle as a frame tick belongs to the frame being closed, and it is counted in that frame.
- R6: Each frame mean is floor(sum / count), or 0 for an empty frame. `win_mean_o` equals (older mean + newer mean) >> 1. It is valid from the first beat of the window and stays stable until the final entry is accepted.
- R7: Once 256 entries are stored in a frame, further intervals in that frame are dropped. `ovf_o` goes to 1 and stays at 1 until reset.
- R8: An empty frame contributes no entries to a window. If both frames of a window are empty, nothing is streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rr_valid_i | input | 1 | An RR interval is present |
| rr_data_i | input | DATA_W | RR interval value |
| frame_tick_i | input | 1 | One-minute boundary; closes the frame being filled |
| rd_valid_o | output | 1 | Stream entry is valid |
| rd_data_o | output | DATA_W | Stream entry |
| rd_last_o | output | 1 | Final entry of the window |
| rd_ready_i | input | 1 | Consumer accepts the entry |
| win_mean_o | output | DATA_W | Mean of the window being streamed |
| ovf_o | output | 1 | Sticky: a frame dropped an interval for lack of space |

## Verification
The assertions check the following on every cycle:
- the stream is held steady under back-pressure;
- `rd_last_o` never appears without `rd_valid_o`;
- the window mean does not change during a stream;
- the overflow flag stays set once raised;
- no stream appears before two ticks have been seen.

Only the bench scenarios can show the rest:
- the order and content of the entries;
- the reuse of the shared minute across consecutive windows;
- the integer mean values;
- the counting of an interval that coincides with a tick;
- the skipping of empty frames;
- the 256-entry limit.

// File: rtl/rrfb_pkg.sv
package rrfb_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_OLD  = 2'd1,
    RD_NEW  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/rrfb_bank_store.sv
module rrfb_bank_store #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 256,
  parameter int NUM_BANKS = 2,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wbank_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] rbank_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_arr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (wbank_i == BANK_W'(b))) mem[waddr_i] <= wdata_i;
    end
    assign rd_arr[b] = mem[raddr_i];
  end

  assign rdata_o = rd_arr[rbank_i];
endmodule

// File: rtl/rrfb_frame_acc.sv
module rrfb_frame_acc #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SUM_W  = DATA_W + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [CNT_W-1:0]  close_cnt_o,
  output logic [SUM_W-1:0]  close_sum_o,
  output logic              ovf_o
);
  logic [CNT_W-1:0] wcnt_q;
  logic [SUM_W-1:0] sum_q;
  logic             ovf_q;
  logic             fire;

  assign fire        = valid_i && (wcnt_q < CNT_W'(DEPTH));
  assign we_o        = fire;
  assign waddr_o     = wcnt_q[ADDR_W-1:0];
  // a write in the tick cycle still belongs to the closing frame
  assign close_cnt_o = wcnt_q + CNT_W'(fire);
  assign close_sum_o = sum_q + (fire ? SUM_W'(data_i) : '0);
  assign ovf_o       = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      sum_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (tick_i) begin
        wcnt_q <= '0;
        sum_q  <= '0;
      end else if (fire) begin
        wcnt_q <= wcnt_q + 1'b1;
        sum_q  <= close_sum_o;
      end
      if (valid_i && !fire) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rrfb_mean_div.sv
module rrfb_mean_div #(
  parameter int NUM_W   = 25,
  parameter int DEN_W   = 9,
  parameter int Q_W     = 16,
  localparam int STEP_W = $clog2(NUM_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [Q_W-1:0]   quot_o
);
  logic [NUM_W-1:0]  num_q;
  logic [DEN_W-1:0]  rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q, done_q;
  logic [DEN_W:0]    rem_sh;
  logic              take;

  assign rem_sh = {rem_q, num_q[NUM_W-1]};
  assign take   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        // empty frame: 0/1 gives a zero mean
        num_q  <= (den_i == '0) ? '0 : num_i;
        den_q  <= (den_i == '0) ? DEN_W'(1) : den_i;
        rem_q  <= '0;
        step_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        num_q  <= {num_q[NUM_W-2:0], take};
        rem_q  <= take ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
        step_q <= step_q + 1'b1;
        if (step_q == STEP_W'(NUM_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = (|num_q[NUM_W-1:Q_W]) ? '1 : num_q[Q_W-1:0];
endmodule

// File: rtl/rr_frame_pingpong.sv
module rr_frame_pingpong
  import rrfb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEC_DEPTH = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rr_valid_i,
  input  logic [DATA_W-1:0] rr_data_i,
  input  logic              frame_tick_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] win_mean_o,
  output logic              ovf_o
);
  localparam int ADDR_W = $clog2(SEC_DEPTH);
  localparam int CNT_W  = $clog2(SEC_DEPTH + 1);
  localparam int SUM_W  = DATA_W + CNT_W;
  localparam int NSEC   = 2;

  logic              wr_bank_q, div_bank_q, old_bank_q, new_bank, rd_bank;
  logic              primed_q, pend_q, mean_pend_q;
  logic [CNT_W-1:0]  cnt_q  [NSEC];
  logic [DATA_W-1:0] mean_q [NSEC];
  logic [CNT_W-1:0]  rptr_q, cnt_old, cnt_new;
  logic [DATA_W-1:0] win_mean_q;
  logic [DATA_W:0]   mean_sum;
  rd_state_e         state_q;

  logic              acc_we;
  logic [ADDR_W-1:0] acc_waddr;
  logic [CNT_W-1:0]  close_cnt;
  logic [SUM_W-1:0]  close_sum;
  logic              div_done;
  logic [DATA_W-1:0] div_quot;
  logic              start_rd, rd_fire, old_end, new_end;

  rrfb_frame_acc #(.DATA_W(DATA_W), .DEPTH(SEC_DEPTH)) u_acc (
    .clk_i, .rst_ni,
    .valid_i     (rr_valid_i),
    .data_i      (rr_data_i),
    .tick_i      (frame_tick_i),
    .we_o        (acc_we),
    .waddr_o     (acc_waddr),
    .close_cnt_o (close_cnt),
    .close_sum_o (close_sum),
    .ovf_o       (ovf_o)
  );

  rrfb_bank_store #(.DATA_W(DATA_W), .DEPTH(SEC_DEPTH), .NUM_BANKS(NSEC)) u_store (
    .clk_i,
    .we_i    (acc_we),
    .wbank_i (wr_bank_q),
    .waddr_i (acc_waddr),
    .wdata_i (rr_data_i),
    .rbank_i (rd_bank),
    .raddr_i (rptr_q[ADDR_W-1:0]),
    .rdata_o (rd_data_o)
  );

  rrfb_mean_div #(.NUM_W(SUM_W), .DEN_W(CNT_W), .Q_W(DATA_W)) u_div (
    .clk_i, .rst_ni,
    .start_i (frame_tick_i),
    .num_i   (close_sum),
    .den_i   (close_cnt),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  // write side: bank swap, frozen counts, section means
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank_q   <= 1'b0;
      div_bank_q  <= 1'b0;
      primed_q    <= 1'b0;
      mean_pend_q <= 1'b0;
      for (int i = 0; i < NSEC; i++) begin
        cnt_q[i]  <= '0;
        mean_q[i] <= '0;
      end
    end else begin
      if (div_done) mean_q[div_bank_q] <= div_quot;
      if (frame_tick_i) begin
        cnt_q[wr_bank_q] <= close_cnt;
        div_bank_q       <= wr_bank_q;
        wr_bank_q        <= ~wr_bank_q;
        primed_q         <= 1'b1;
        mean_pend_q      <= 1'b1;
      end else if (div_done) begin
        mean_pend_q <= 1'b0;
      end
    end
  end

  // read side
  assign new_bank   = ~old_bank_q;
  assign rd_bank    = (state_q == RD_NEW) ? new_bank : old_bank_q;
  assign cnt_old    = cnt_q[old_bank_q];
  assign cnt_new    = cnt_q[new_bank];
  assign old_end    = rptr_q == (cnt_old - CNT_W'(1));
  assign new_end    = rptr_q == (cnt_new - CNT_W'(1));
  assign rd_valid_o = state_q != RD_IDLE;
  assign rd_fire    = rd_valid_o && rd_ready_i;
  assign rd_last_o  = ((state_q == RD_NEW) && new_end) ||
                      ((state_q == RD_OLD) && old_end && (cnt_new == '0));
  assign start_rd   = pend_q && !mean_pend_q && (state_q == RD_IDLE);
  assign mean_sum   = {1'b0, mean_q[0]} + {1'b0, mean_q[1]};
  assign win_mean_o = win_mean_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      state_q    <= RD_IDLE;
      old_bank_q <= 1'b0;
      rptr_q     <= '0;
      win_mean_q <= '0;
    end else begin
      if (frame_tick_i && primed_q) pend_q <= 1'b1;
      else if (start_rd)            pend_q <= 1'b0;
      unique case (state_q)
        RD_IDLE: if (start_rd) begin
          // bank now being refilled holds the older frame
          old_bank_q <= wr_bank_q;
          rptr_q     <= '0;
          win_mean_q <= mean_sum[DATA_W:1];
          if (cnt_q[wr_bank_q] != '0)       state_q <= RD_OLD;
          else if (cnt_q[~wr_bank_q] != '0) state_q <= RD_NEW;
        end
        RD_OLD: if (rd_fire) begin
          if (old_end) begin
            rptr_q  <= '0;
            state_q <= (cnt_new != '0) ? RD_NEW : RD_IDLE;
          end else begin
            rptr_q <= rptr_q + 1'b1;
          end
        end
        RD_NEW: if (rd_fire) begin
          if (new_end) begin
            rptr_q  <= '0;
            state_q <= RD_IDLE;
          end else begin
            rptr_q <= rptr_q + 1'b1;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rrfb_chk.sv
module rrfb_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_tick_i,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic              rd_last_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [DATA_W-1:0] win_mean_o,
  input logic              ovf_o
);
  logic [1:0] ticks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ticks_q <= '0;
    else if (frame_tick_i && ticks_q != 2) ticks_q <= ticks_q + 1'b1;
  end

  // R2
  no_early_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ticks_q < 2) |-> !rd_valid_o);

  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=>
      (rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o)));

  // R4
  last_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  // R6
  mean_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !(rd_ready_i && rd_last_o)) |=> $stable(win_mean_o));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

bind rr_frame_pingpong rrfb_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_tick_i (frame_tick_i),
  .rd_valid_o   (rd_valid_o),
  .rd_ready_i   (rd_ready_i),
  .rd_last_o    (rd_last_o),
  .rd_data_o    (rd_data_o),
  .win_mean_o   (win_mean_o),
  .ovf_o        (ovf_o)
);

// File: tb/rr_frame_pingpong_bench.sv
module rr_frame_pingpong_bench;
  localparam int DW  = 16;
  localparam int DEP = 256;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rr_valid_i = 1'b0;
  logic [DW-1:0] rr_data_i = '0;
  logic          frame_tick_i = 1'b0;
  logic          rd_ready_i = 1'b0;
  logic          rd_valid_o, rd_last_o, ovf_o;
  logic [DW-1:0] rd_data_o, win_mean_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 0;

  logic [DW-1:0] cur_q[$];
  logic [DW-1:0] prev_q[$];
  logic [DW-1:0] exp_q[$];
  int            exp_mean;
  int            frames_closed = 0;

  always #5 clk_i = ~clk_i;

  rr_frame_pingpong #(.DATA_W(DW), .SEC_DEPTH(DEP)) u_rr_frame_pingpong (.*);

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fmean(logic [DW-1:0] q[$]);
    longint s = 0;
    if (q.size() == 0) return 0;
    foreach (q[i]) s += q[i];
    return int'(s / q.size());
  endfunction

  task automatic model_close();
    exp_q.delete();
    if (frames_closed >= 1) begin
      foreach (prev_q[i]) exp_q.push_back(prev_q[i]);
      foreach (cur_q[i])  exp_q.push_back(cur_q[i]);
      exp_mean = (fmean(prev_q) + fmean(cur_q)) >> 1;
    end
    prev_q = cur_q;
    cur_q.delete();
    frames_closed++;
  endtask

  task automatic push(logic [DW-1:0] v);
    rr_valid_i = 1'b1;
    rr_data_i  = v;
    if (cur_q.size() < DEP) cur_q.push_back(v);
    @(negedge clk_i);
    rr_valid_i = 1'b0;
  endtask

  task automatic tick(bit with_val, logic [DW-1:0] v);
    frame_tick_i = 1'b1;
    if (with_val) begin
      rr_valid_i = 1'b1;
      rr_data_i  = v;
      if (cur_q.size() < DEP) cur_q.push_back(v);
    end
    model_close();
    @(negedge clk_i);
    frame_tick_i = 1'b0;
    rr_valid_i   = 1'b0;
  endtask

  task automatic expect_silence(string req, int cycles);
    for (int i = 0; i < cycles; i++) begin
      chk(!rd_valid_o, req, "no stream rd_valid", rd_valid_o, 0);
      @(negedge clk_i);
    end
  endtask

  task automatic drain(string req, bit stall);
    int idx = 0;
    int guard = 0;
    int total = exp_q.size();
    if (total == 0) begin
      expect_silence(req, 80);
      return;
    end
    while (!rd_valid_o && guard < 200) begin
      @(negedge clk_i);
      guard++;
    end
    chk(rd_valid_o, req, "window released", rd_valid_o, 1);
    chk(win_mean_o == DW'(exp_mean), "R6", "window mean", win_mean_o, exp_mean);
    guard = 0;
    while (idx < total && guard < 4 * total + 10) begin
      chk(rd_valid_o, req, "valid during stream", rd_valid_o, 1);
      chk(rd_data_o == exp_q[idx], req, $sformatf("entry %0d", idx), rd_data_o, exp_q[idx]);
      chk(rd_last_o == (idx == total - 1), "R4", $sformatf("last at %0d", idx),
          rd_last_o, idx == total - 1);
      chk(win_mean_o == DW'(exp_mean), "R6", "mean held", win_mean_o, exp_mean);
      rd_ready_i = stall ? guard[0] : 1'b1;
      if (rd_ready_i) idx++;
      @(negedge clk_i);
      guard++;
    end
    rd_ready_i = 1'b0;
    chk(idx == total, req, "entries taken", idx, total);
    expect_silence(req, 3);
  endtask

  task automatic t_reset();
    chk(!rd_valid_o, "R1", "rd_valid after reset", rd_valid_o, 0);
    chk(!rd_last_o, "R1", "rd_last after reset", rd_last_o, 0);
    chk(!ovf_o, "R1", "ovf after reset", ovf_o, 0);
    chk(win_mean_o == 0, "R1", "mean after reset", win_mean_o, 0);
  endtask

  task automatic t_first_frame();
    for (int i = 0; i < 5; i++) push(DW'(800 + 10 * i));
    tick(0, '0);
    expect_silence("R2", 60);
  endtask

  task automatic t_second_frame_tick_write();
    push(DW'(700));
    push(DW'(905));
    push(DW'(1003));
    tick(1, DW'(1211));  // R5: value in tick cycle closes with this frame
    drain("R3", 0);
    chk(exp_q.size() == 9, "R5", "window size incl tick value", exp_q.size(), 9);
  endtask

  task automatic t_overlap_stall();
    push(DW'(640));
    push(DW'(655));
    push(DW'(671));
    tick(0, '0);
    drain("R3", 1);
  endtask

  task automatic t_empty_frames();
    tick(0, '0);
    drain("R8", 0);       // older has data, newer empty
    tick(0, '0);
    drain("R8", 0);       // both empty: nothing streamed
    push(DW'(512));
    push(DW'(515));
    tick(0, '0);
    drain("R8", 0);       // older empty, newer only
  endtask

  task automatic t_overflow();
    chk(!ovf_o, "R7", "ovf before limit", ovf_o, 0);
    for (int i = 0; i < DEP + 2; i++) push(DW'(300 + 3 * i));
    @(negedge clk_i);
    chk(ovf_o, "R7", "ovf after limit", ovf_o, 1);
    tick(0, '0);
    drain("R7", 0);
    push(DW'(999));
    tick(0, '0);
    drain("R3", 0);
    chk(ovf_o, "R7", "ovf sticky", ovf_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done_flag) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_first_frame();
    t_second_frame_tick_write();
    t_overlap_stall();
    t_empty_frames();
    t_overflow();
    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule